// File: doc/BRIEF.md
# Reed-Solomon Syndrome Calculator

This block takes a received Reed-Solomon codeword, one symbol per clock, and evaluates the received polynomial at each of the N-K roots of the generator polynomial. The first symbol of a block is the highest-degree coefficient. Every root is a power of the primitive element alpha. Its exponent is ROOT_STEP*(ROOT_START+j). The field is built from an irreducible polynomial, which is given as an integer (the polynomial evaluated at x = 2). The symbol width, codeword length and data length are parameters. Shortened codes, where N is less than 2^SYM_W - 1, work without any change.

One clock cycle after the last symbol of a block is accepted, the block presents the whole syndrome vector, raises a one-cycle completion strobe and sets a flag when every syndrome is zero. A later correction stage uses that flag to pass a clean block straight through. The accumulators clear in the same cycle, so the next block can begin on the very next symbol. A parameter selects how the framing input marks blocks: either a single pulse on the first symbol, or a level that is high over the data symbols and low over the check symbols. The block also has a clock enable, a synchronous clear and an active-low asynchronous reset.

Top module: `rs_syndrome`

## Requirements
- R1: After the final symbol of a block, syndrome j (j = 0 .. N-K-1) sits in bits [j*SYM_W +: SYM_W] of `synd`. It equals the sum over i of r_i * alpha^(e_j*(N-1-i)), where r_i is the i-th symbol received and e_j = ROOT_STEP*(ROOT_START+j) mod (2^SYM_W - 1). Alpha is the element 2 of the field defined by FIELD_POLY.
- R2: R1 holds for any symbol width from 3 to 12, for any field polynomial given by its integer value, and for shortened lengths N < 2^SYM_W - 1.
- R3: `done` is high for exactly one cycle. This is the cycle after the clock edge that accepts the N-th symbol of a block. `synd` changes only together with `done`, a synchronous clear or a reset, and a new block may start on the very next symbol.
- R4: `zero` changes only together with `synd`. While `done` is high, `zero` is 1 exactly when every syndrome is zero.
- R5: When SYNC_MODE = 0, a sampled `sync` = 1 marks its symbol as the first symbol of a block. This applies even in the middle of a block, which then restarts. While no block is open, symbols sampled with `sync` = 0 are ignored.
- R6: When SYNC_MODE = 1, a block opens on a symbol sampled with `sync` = 1 when the previously sampled `sync` was 0. After that, the level of `sync` is ignored until N symbols have been taken. `sync` is expected to be high for the K data symbols and low for the check symbols.
- R7: While `ce` = 0, no input is sampled, no symbol is counted, `done` stays low, and `synd` and `zero` hold their values.
- R8: `srst` = 1 sampled with `ce` = 1 abandons any partial block. It clears `synd` to 0 and `zero` to 0, and `done` is low in the following cycle.
- R9: `rst_n` = 0 clears all state and outputs at once, with no clock edge needed, and it overrides every other input. After reset, `synd` = 0, `zero` = 0 and `done` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| srst | input | 1 | Synchronous clear, honoured only when ce = 1 |
| ce | input | 1 | Clock enable; when low, every synchronous input is ignored |
| sync | input | 1 | Block framing: a start pulse or a data-symbol level, chosen by SYNC_MODE |
| sym_in | input | SYM_W | Received code symbol |
| synd | output | (N-K)*SYM_W | Syndrome vector; syndrome j at bits [j*SYM_W +: SYM_W] |
| done | output | 1 | One-cycle strobe when a new syndrome vector is valid |
| zero | output | 1 | Every syndrome of the last finished block is zero |

## Verification
A wrong accumulator or a wrong root constant stays invisible until the completion strobe. It then shows as a wrong syndrome vector and often as a wrong zero flag, one cycle after the final symbol of that block. A wrong symbol counter or framing state shows up instead as a strobe in the wrong cycle, with no strobe at all, or with syndromes that are nonzero for a clean codeword. A clean codeword after idle junk, a mid-block restart or a clear therefore checks the control state. Random codewords with known error counts, in two field configurations, check the arithmetic.

// File: rtl/rs_syndrome.sv
module rs_syndrome #(
  parameter int SYM_W      = 8,
  parameter int N          = 204,
  parameter int K          = 188,
  parameter int FIELD_POLY = 285,
  parameter int ROOT_START = 0,
  parameter int ROOT_STEP  = 1,
  parameter int SYNC_MODE  = 0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       srst,
  input  logic                       ce,
  input  logic                       sync,
  input  logic [SYM_W-1:0]           sym_in,
  output logic [(N-K)*SYM_W-1:0]     synd,
  output logic                       done,
  output logic                       zero
);
  localparam int NSYN = N - K;
  localparam int CW   = $clog2(N + 1);
  localparam int Q    = (1 << SYM_W) - 1;
  localparam logic [SYM_W-1:0] POLY_LO = SYM_W'(FIELD_POLY);

  function automatic logic [SYM_W-1:0] gf_mul(input logic [SYM_W-1:0] a, input logic [SYM_W-1:0] b);
    logic [SYM_W-1:0] p, x;
    p = '0;
    x = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) p = p ^ x;
      x = x[SYM_W-1] ? ((x << 1) ^ POLY_LO) : (x << 1);
    end
    return p;
  endfunction

  function automatic int root_exp(input int j);
    return ((ROOT_STEP % Q) * ((ROOT_START + j) % Q)) % Q;
  endfunction

  function automatic logic [SYM_W-1:0] alpha_pow(input int e);
    logic [SYM_W-1:0] r;
    r = SYM_W'(1);
    for (int i = 0; i < e; i++) r = gf_mul(r, SYM_W'(2));
    return r;
  endfunction

  logic [SYM_W-1:0] acc [NSYN];
  logic [SYM_W-1:0] nxt [NSYN];
  logic [NSYN*SYM_W-1:0] nxt_flat;
  logic [CW-1:0] cnt;
  logic busy, sync_q;

  logic new_blk, take, fin;
  assign new_blk = (SYNC_MODE == 0) ? sync : (!busy && sync && !sync_q);
  assign take    = ce && (busy || new_blk);
  assign fin     = ce && busy && !new_blk && (cnt == CW'(N - 1));

  for (genvar j = 0; j < NSYN; j++) begin : g_root
    localparam logic [SYM_W-1:0] MULT = alpha_pow(root_exp(j));
    assign nxt[j] = new_blk ? sym_in : (gf_mul(acc[j], MULT) ^ sym_in);
    assign nxt_flat[j*SYM_W +: SYM_W] = nxt[j];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < NSYN; j++) acc[j] <= '0;
      cnt    <= '0;
      busy   <= 1'b0;
      sync_q <= 1'b0;
      synd   <= '0;
      zero   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (ce) begin
        sync_q <= sync;
        if (srst) begin
          for (int j = 0; j < NSYN; j++) acc[j] <= '0;
          cnt  <= '0;
          busy <= 1'b0;
          synd <= '0;
          zero <= 1'b0;
        end else if (fin) begin
          for (int j = 0; j < NSYN; j++) acc[j] <= '0;
          cnt  <= '0;
          busy <= 1'b0;
          synd <= nxt_flat;
          zero <= ~|nxt_flat;
          done <= 1'b1;
        end else if (take) begin
          for (int j = 0; j < NSYN; j++) acc[j] <= nxt[j];
          cnt  <= new_blk ? CW'(1) : cnt + CW'(1);
          busy <= 1'b1;
        end
      end
    end
  end
endmodule

module rs_syndrome_chk #(
  parameter int SW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          srst,
  input logic          ce,
  input logic [SW-1:0] synd,
  input logic          done,
  input logic          zero
);
  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R3
  synd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !$past(ce && srst)) |-> $stable(synd));
  // R4
  zero_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (zero == (synd == '0)));
  // R4
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !$past(ce && srst)) |-> $stable(zero));
  // R7
  ce_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> (!done && $stable(synd) && $stable(zero)));
  // R8
  srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && srst) |=> (!done && synd == '0 && !zero));
endmodule

bind rs_syndrome rs_syndrome_chk #(.SW((N - K) * SYM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .srst(srst), .ce(ce),
  .synd(synd), .done(done), .zero(zero)
);

// File: tb/sim_rs_syndrome.sv
module sim_rs_syndrome;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic srst0 = 0, ce0 = 1, sync0 = 0;
  logic [7:0] sym0 = 0;
  logic [127:0] synd0;
  logic done0, zero0;
  logic srst1 = 0, ce1 = 1, sync1 = 0;
  logic [3:0] sym1 = 0;
  logic [15:0] synd1;
  logic done1, zero1;

  rs_syndrome u0 (.clk(clk), .rst_n(rst_n), .srst(srst0), .ce(ce0), .sync(sync0),
    .sym_in(sym0), .synd(synd0), .done(done0), .zero(zero0));
  rs_syndrome #(.SYM_W(4), .N(12), .K(8), .FIELD_POLY(19), .ROOT_START(1),
    .ROOT_STEP(2), .SYNC_MODE(1)) u1 (.clk(clk), .rst_n(rst_n), .srst(srst1),
    .ce(ce1), .sync(sync1), .sym_in(sym1), .synd(synd1), .done(done1), .zero(zero1));

  int checks = 0, fails = 0;
  int unsigned seed = 32'h1234_5678;
  int cm, cpoly, cn, ck, cs, cr, cq;
  int cw [255];
  int mdl [16];
  int g [17];

  localparam int VEC [10][3] = '{
    '{0, 0, 0}, '{0, 1, 0}, '{0, 3, 1}, '{0, 8, 0}, '{0, 20, 0},
    '{1, 0, 0}, '{1, 1, 1}, '{1, 2, 0}, '{1, 5, 0}, '{0, 0, 1}};

  function automatic int rnd(int lim);
    seed = seed * 1664525 + 1013904223;
    return int'((seed >> 8) % lim);
  endfunction

  function automatic int gmul(int a, int b);
    int p = 0;
    for (int i = 0; i < cm; i++) begin
      if ((b >> i) & 1) p = p ^ a;
      a = a << 1;
      if ((a >> cm) & 1) a = a ^ cpoly;
    end
    return p;
  endfunction

  function automatic int gpow(int e);
    int r = 1;
    for (int i = 0; i < e; i++) r = gmul(r, 2);
    return r;
  endfunction

  function automatic int rexp(int j);
    return ((cr % cq) * ((cs + j) % cq)) % cq;
  endfunction

  task automatic set_cfg(int inst);
    if (inst == 0) begin cm = 8; cpoly = 285; cn = 204; ck = 188; cs = 0; cr = 1; end
    else begin cm = 4; cpoly = 19; cn = 12; ck = 8; cs = 1; cr = 2; end
    cq = (1 << cm) - 1;
  endtask

  task automatic build(int inst, int nerr);
    int p, fb, root;
    int rem [16];
    set_cfg(inst);
    p = cn - ck;
    for (int i = 0; i < 17; i++) g[i] = 0;
    g[0] = 1;
    for (int i = 0; i < p; i++) begin
      root = gpow(rexp(i));
      for (int d = i + 1; d >= 0; d--) g[d] = ((d > 0) ? g[d-1] : 0) ^ gmul(g[d], root);
    end
    for (int i = 0; i < 16; i++) rem[i] = 0;
    for (int i = 0; i < ck; i++) begin
      cw[i] = rnd(cq + 1);
      fb = cw[i] ^ rem[p-1];
      for (int d = p - 1; d > 0; d--) rem[d] = rem[d-1] ^ gmul(fb, g[d]);
      rem[0] = gmul(fb, g[0]);
    end
    for (int i = 0; i < p; i++) cw[ck + i] = rem[p - 1 - i];
    for (int e = 0; e < nerr; e++) begin
      int pos = rnd(cn);
      cw[pos] = cw[pos] ^ (1 + rnd(cq));
    end
    for (int j = 0; j < p; j++) begin
      int a = gpow(rexp(j));
      int s = 0;
      for (int i = 0; i < cn; i++) s = gmul(s, a) ^ cw[i];
      mdl[j] = s;
    end
  endtask

  task automatic chk(logic ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int got(int inst, int j);
    return (inst == 0) ? int'(synd0[j*8 +: 8]) : int'(synd1[j*4 +: 4]);
  endfunction

  task automatic check_result(int inst, string req);
    int bad = 0, first_bad = -1, allz = 1;
    for (int j = 0; j < cn - ck; j++) begin
      if (mdl[j] != 0) allz = 0;
      if (got(inst, j) != mdl[j]) begin bad++; if (first_bad < 0) first_bad = j; end
    end
    chk((inst == 0 ? done0 : done1) == 1'b1, "R3 done after last symbol",
        int'(inst == 0 ? done0 : done1), 1);
    chk(bad == 0, req, first_bad < 0 ? 0 : got(inst, first_bad),
        first_bad < 0 ? 0 : mdl[first_bad]);
    chk(int'(inst == 0 ? zero0 : zero1) == allz, "R4 zero flag",
        int'(inst == 0 ? zero0 : zero1), allz);
  endtask

  task automatic feed(int inst, int gaps);
    for (int i = 0; i < cn; i++) begin
      @(negedge clk);
      if (gaps != 0 && i % 7 == 3) begin
        if (inst == 0) begin ce0 = 0; sym0 = 8'(rnd(256)); sync0 = 1; end
        else begin ce1 = 0; sym1 = 4'(rnd(16)); sync1 = 0; end
        @(negedge clk);
      end
      if (inst == 0) begin ce0 = 1; sym0 = 8'(cw[i]); sync0 = (i == 0); end
      else begin ce1 = 1; sym1 = 4'(cw[i]); sync1 = (i < ck); end
    end
    @(posedge clk); #1;
  endtask

  task automatic junk0(int cnt, logic first_sync);
    for (int i = 0; i < cnt; i++) begin
      @(negedge clk);
      ce0 = 1; sym0 = 8'(rnd(256)); sync0 = first_sync && (i == 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [127:0] held;
    repeat (3) @(posedge clk);
    #1;
    // R9 reset values
    chk(done0 == 0 && zero0 == 0 && synd0 == 0, "R9 reset state", int'(synd0[7:0]), 0);
    @(negedge clk); rst_n = 1;

    for (int v = 0; v < 10; v++) begin
      build(VEC[v][0], VEC[v][1]);
      feed(VEC[v][0], VEC[v][2]);
      // R1 R7 on u0; R2 R6 on u1 (gaps exercise R7 too)
      check_result(VEC[v][0], VEC[v][0] == 0 ? "R1 R7 syndromes" : "R2 R6 syndromes");
    end

    @(posedge clk); #1;
    chk(done0 == 0, "R3 done one cycle", int'(done0), 0);

    // R5 idle symbols without sync are ignored
    junk0(30, 1'b0);
    @(posedge clk); #1;
    chk(done0 == 0, "R5 no done while idle", int'(done0), 0);
    build(0, 0); feed(0, 0); check_result(0, "R5 idle ignore");

    // R5 sync mid-block restarts
    junk0(40, 1'b1);
    build(0, 0); feed(0, 0); check_result(0, "R5 restart");

    // R8 synchronous clear
    junk0(50, 1'b1);
    @(negedge clk); srst0 = 1; ce0 = 1; sync0 = 0;
    @(posedge clk); #1;
    chk(synd0 == 0 && zero0 == 0 && done0 == 0, "R8 srst clears", int'(synd0[7:0]), 0);
    @(negedge clk); srst0 = 0;
    build(0, 0); feed(0, 0); check_result(0, "R8 after srst");

    // R7 clock enable low holds outputs
    build(0, 4); feed(0, 0); check_result(0, "R1 errors");
    held = synd0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); ce0 = 0; sync0 = 1; sym0 = 8'(rnd(256));
    end
    @(posedge clk); #1;
    chk(synd0 == held && done0 == 0, "R7 ce hold", int'(synd0[7:0]), int'(held[7:0]));
    @(negedge clk); ce0 = 1; sync0 = 0;

    // R9 asynchronous reset mid-block
    junk0(20, 1'b1);
    @(negedge clk); #2 rst_n = 0; #1;
    chk(synd0 == 0 && zero0 == 0 && done0 == 0, "R9 async clear", int'(synd0[7:0]), 0);
    @(negedge clk); rst_n = 1;
    build(0, 0); feed(0, 0); check_result(0, "R9 after reset");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule